// File: doc/BRIEF.md
# Port-Mapped Video and Memory Control Unit

This block holds the video and memory setup of a small 8-bit machine and updates it from processor I/O writes to one control port. The upper two bits of each data byte written to that port select one of four commands. The first command picks a pen or the border. The second stores a colour number into whichever entry was picked. The third sets the screen mode and the two ROM enables. The fourth chooses one of eight RAM layouts and an expansion bank.

The colour table has sixteen pens plus one border entry. It is presented as one flat vector. On the memory side, the top two bits of the processor address choose a 16 KB window. The block translates that window into a physical RAM block number under the current layout. It also raises a flag when a read in the bottom or top window must be served by an enabled ROM.

Top module: `vidmem_ctrl`

## Requirements
- R1: A write acts only when `io_wr` is 1 and `io_addr[15:8]` equals 0x7F. The low address byte never changes the outcome. A write to any other upper byte leaves every output unchanged.
- R2: Command 00 (`io_data[7:6]`) picks the colour-table entry. With `io_data[4]`=1 it picks the border, which is entry 16. Otherwise it picks pen `io_data[3:0]`.
- R3: Command 01 stores `io_data[4:0]` into the picked entry, which appears at `pal_out[5*i +: 5]`. Values 27 to 31 are stored unchanged, and no other entry changes.
- R4: Command 10 loads `scr_mode` from `io_data[1:0]`. `io_data[2]`=1 turns off the bottom-window ROM and `io_data[3]`=1 turns off the top-window ROM. `io_data[4]` changes neither the mode nor the ROM enables.
- R5: Command 11 loads the RAM layout from `io_data[2:0]` and the expansion bank from `io_data[5:3]`.
- R6: With expansion bank 0, windows 0/1/2/3 map as follows. Layout 0 gives 0,1,2,3. Layout 1 gives 0,1,2,7. Layout 2 gives 4,5,6,7. Layout 3 gives 0,3,2,7. Layouts 4 to 7 give 0,L,2,3, where L is the layout number.
- R7: With expansion bank E, a table block B of 4 to 7 becomes B+4*E. Blocks 0 to 3 are never moved.
- R8: `rom_sel` is 1 for a read (`mem_wr`=0) in window 0 while the bottom ROM is on, or in window 3 while the top ROM is on. It is 0 for every write. `phys_bank` always gives the RAM block.
- R9: After reset, the layout and expansion bank are 0, the mode is 1, both ROMs are on, pen 0 is picked and all table entries are 0.
- R10: A control write shows on the outputs after the rising edge that samples it, and not before. Address translation and `rom_sel` follow `mem_addr` and `mem_wr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_data | input | 8 | I/O write data |
| mem_addr | input | 16 | Processor memory address |
| mem_wr | input | 1 | 1 = memory write, 0 = read |
| phys_bank | output | 6 | Physical RAM block for the access |
| rom_sel | output | 1 | Read is served by ROM |
| scr_mode | output | 2 | Screen mode |
| pal_out | output | 85 | Colour table, 17 entries of 5 bits, border last |

## Verification
Every command takes effect at the single rising edge that samples `io_wr`. The mode, the colour table and the window map are therefore due one edge after the write. The memory map is combinational, so `phys_bank` and `rom_sel` are due in the same cycle as `mem_addr` and `mem_wr`.

The bench drives each write at a falling edge and compares the registered outputs at the next falling edge. It probes the map a short delay after each change of address. One directed case looks at the mode while the strobe is high, before the edge, to confirm nothing changes early.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic [1:0] {
    CMD_PEN     = 2'b00,
    CMD_COLOUR  = 2'b01,
    CMD_MODEROM = 2'b10,
    CMD_RAMCFG  = 2'b11
  } vmc_cmd_e;

  localparam int unsigned WIN_COUNT  = 4;
  localparam int unsigned CFG_W      = 3;
  localparam logic [1:0]  MODE_RESET = 2'd1;
endpackage

// File: rtl/vmc_port_decode.sv
module vmc_port_decode
  import vmc_pkg::*;
#(
  parameter logic [7:0] PORT_HI = 8'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] addr_hi,
  input  logic [1:0] cmd_bits,
  output logic       pen_we,
  output logic       col_we,
  output logic       ctl_we,
  output logic       ram_we
);
  logic     hit;
  vmc_cmd_e cmd;

  assign hit = io_wr && (addr_hi == PORT_HI);
  assign cmd = vmc_cmd_e'(cmd_bits);

  always_comb begin
    pen_we = 1'b0;
    col_we = 1'b0;
    ctl_we = 1'b0;
    ram_we = 1'b0;
    if (hit) begin
      unique case (cmd)
        CMD_PEN:     pen_we = 1'b1;
        CMD_COLOUR:  col_we = 1'b1;
        CMD_MODEROM: ctl_we = 1'b1;
        CMD_RAMCFG:  ram_we = 1'b1;
        default:     pen_we = 1'b0;
      endcase
    end
  end

  // R1
  foreign_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi != PORT_HI) |-> !(pen_we || col_we || ctl_we || ram_we));

  // R1
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pen_we, col_we, ctl_we, ram_we}));
endmodule

// File: rtl/vmc_palette.sv
module vmc_palette #(
  parameter int unsigned NUM_PENS = 16,
  parameter int unsigned COL_W    = 5,
  localparam int unsigned PAL_N   = NUM_PENS + 1,
  localparam int unsigned SEL_W   = $clog2(PAL_N),
  localparam int unsigned PEN_W   = $clog2(NUM_PENS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pen_we,
  input  logic                   col_we,
  input  logic [4:0]             cmd_bits,
  output logic [PAL_N*COL_W-1:0] pal_flat
);
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (pen_we) begin
      if (cmd_bits[4]) sel_d = SEL_W'(NUM_PENS);
      else             sel_d = SEL_W'(cmd_bits[PEN_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  for (genvar g = 0; g < PAL_N; g++) begin : g_entry
    logic [COL_W-1:0] ent_q, ent_d;
    logic             ent_en;

    assign ent_en = col_we && (sel_q == SEL_W'(g));

    always_comb begin
      ent_d = ent_q;
      if (ent_en) ent_d = cmd_bits[COL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign pal_flat[g*COL_W +: COL_W] = ent_q;
  end

  // R2
  border_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_we && cmd_bits[4]) |=> (sel_q == SEL_W'(NUM_PENS)));

  // R3
  col_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_we |=> (pal_flat[$past(sel_q)*COL_W +: COL_W] == $past(cmd_bits[COL_W-1:0])));

  // R3
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_we |=> $stable(pal_flat));
endmodule

// File: rtl/vmc_sysregs.sv
module vmc_sysregs
  import vmc_pkg::*;
#(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ram_we,
  input  logic [5:0]       cmd_bits,
  output logic [1:0]       mode,
  output logic             lo_rom_en,
  output logic             hi_rom_en,
  output logic [CFG_W-1:0] ram_cfg,
  output logic [EXP_W-1:0] exp_bank
);
  logic [1:0]       mode_q, mode_d;
  logic             lo_q, lo_d, hi_q, hi_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [EXP_W-1:0] exp_q, exp_d;

  always_comb begin
    mode_d = mode_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (ctl_we) begin
      mode_d = cmd_bits[1:0];
      lo_d   = ~cmd_bits[2];
      hi_d   = ~cmd_bits[3];
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    exp_d = exp_q;
    if (ram_we) begin
      cfg_d = cmd_bits[CFG_W-1:0];
      exp_d = cmd_bits[3 +: EXP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      lo_q   <= 1'b1;
      hi_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      exp_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      exp_q <= exp_d;
    end
  end

  assign mode      = mode_q;
  assign lo_rom_en = lo_q;
  assign hi_rom_en = hi_q;
  assign ram_cfg   = cfg_q;
  assign exp_bank  = exp_q;

  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (mode == $past(cmd_bits[1:0])));

  // R4
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable(mode) && $stable(lo_rom_en) && $stable(hi_rom_en)));

  // R5
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we |=> ($stable(ram_cfg) && $stable(exp_bank)));
endmodule

// File: rtl/vmc_bank_map.sv
module vmc_bank_map
  import vmc_pkg::*;
#(
  parameter int unsigned EXP_W  = 3,
  parameter int unsigned BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  ram_cfg,
  input  logic [EXP_W-1:0]  exp_bank,
  input  logic              lo_rom_en,
  input  logic              hi_rom_en,
  input  logic [1:0]        win,
  input  logic              mem_wr,
  output logic [BANK_W-1:0] phys_bank,
  output logic              rom_sel
);
  logic [BANK_W-1:0] win_bank [WIN_COUNT];
  logic [BANK_W-1:0] exp_ofs;

  assign exp_ofs = BANK_W'({exp_bank, 2'b00});

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    logic [2:0] blk;
    if (w == 0) begin : g_w0
      assign blk = (ram_cfg == 3'd2) ? 3'd4 : 3'd0;
    end else if (w == 1) begin : g_w1
      always_comb begin
        case (ram_cfg)
          3'd0, 3'd1: blk = 3'd1;
          3'd2:       blk = 3'd5;
          3'd3:       blk = 3'd3;
          default:    blk = ram_cfg;
        endcase
      end
    end else if (w == 2) begin : g_w2
      assign blk = (ram_cfg == 3'd2) ? 3'd6 : 3'd2;
    end else begin : g_w3
      assign blk = (ram_cfg inside {3'd1, 3'd2, 3'd3}) ? 3'd7 : 3'd3;
    end
    assign win_bank[w] = BANK_W'(blk) + (blk[2] ? exp_ofs : '0);
  end

  assign phys_bank = win_bank[win];
  assign rom_sel   = !mem_wr && (((win == 2'd0) && lo_rom_en) ||
                                 ((win == 2'd3) && hi_rom_en));

  // R6
  win2_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win == 2'd2) && (ram_cfg != 3'd2)) |-> (phys_bank == BANK_W'(2)));

  // R7
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win == 2'd0) && (ram_cfg != 3'd2)) |-> (phys_bank == '0));

  // R8
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !rom_sel);

  // R8
  rom_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win inside {2'd1, 2'd2}) |-> !rom_sel);
endmodule

// File: rtl/vidmem_ctrl.sv
module vidmem_ctrl
  import vmc_pkg::*;
#(
  parameter logic [7:0]  PORT_HI  = 8'h7F,
  parameter int unsigned NUM_PENS = 16,
  parameter int unsigned COL_W    = 5,
  parameter int unsigned EXP_W    = 3,
  localparam int unsigned PAL_N   = NUM_PENS + 1,
  localparam int unsigned BANK_W  = $clog2(4 * (2 ** EXP_W) + 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_wr,
  input  logic [15:0]            io_addr,
  input  logic [7:0]             io_data,
  input  logic [15:0]            mem_addr,
  input  logic                   mem_wr,
  output logic [BANK_W-1:0]      phys_bank,
  output logic                   rom_sel,
  output logic [1:0]             scr_mode,
  output logic [PAL_N*COL_W-1:0] pal_out
);
  logic             rst_q1, rst_q2, rst_int_n;
  logic             pen_we, col_we, ctl_we, ram_we;
  logic             lo_rom_en, hi_rom_en;
  logic [CFG_W-1:0] ram_cfg;
  logic [EXP_W-1:0] exp_bank;
  logic             unused_bits;

  assign unused_bits = ^{io_addr[7:0], mem_addr[13:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_int_n = rst_q2;

  vmc_port_decode #(.PORT_HI(PORT_HI)) i_decode (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .io_wr    (io_wr),
    .addr_hi  (io_addr[15:8]),
    .cmd_bits (io_data[7:6]),
    .pen_we   (pen_we),
    .col_we   (col_we),
    .ctl_we   (ctl_we),
    .ram_we   (ram_we)
  );

  vmc_palette #(.NUM_PENS(NUM_PENS), .COL_W(COL_W)) i_palette (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pen_we   (pen_we),
    .col_we   (col_we),
    .cmd_bits (io_data[4:0]),
    .pal_flat (pal_out)
  );

  vmc_sysregs #(.EXP_W(EXP_W)) i_sysregs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_we    (ctl_we),
    .ram_we    (ram_we),
    .cmd_bits  (io_data[5:0]),
    .mode      (scr_mode),
    .lo_rom_en (lo_rom_en),
    .hi_rom_en (hi_rom_en),
    .ram_cfg   (ram_cfg),
    .exp_bank  (exp_bank)
  );

  vmc_bank_map #(.EXP_W(EXP_W), .BANK_W(BANK_W)) i_bank_map (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ram_cfg   (ram_cfg),
    .exp_bank  (exp_bank),
    .lo_rom_en (lo_rom_en),
    .hi_rom_en (hi_rom_en),
    .win       (mem_addr[15:14]),
    .mem_wr    (mem_wr),
    .phys_bank (phys_bank),
    .rom_sel   (rom_sel)
  );
endmodule

// File: tb/test_vidmem_ctrl.sv
module test_vidmem_ctrl;
  logic        clk;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_data;
  logic [15:0] mem_addr;
  logic        mem_wr;
  logic [5:0]  phys_bank;
  logic        rom_sel;
  logic [1:0]  scr_mode;
  logic [84:0] pal_out;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_pal [17];
  int         m_sel;
  logic [1:0] m_mode;
  logic       m_lo, m_hi;
  int         m_cfg, m_exp;

  vidmem_ctrl i_vidmem_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .phys_bank(phys_bank), .rom_sel(rom_sel), .scr_mode(scr_mode),
    .pal_out(pal_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_bank(int cfg, int ex, int w);
    int b;
    int tbl [8][4] = '{'{0,1,2,3}, '{0,1,2,7}, '{4,5,6,7}, '{0,3,2,7},
                       '{0,4,2,3}, '{0,5,2,3}, '{0,6,2,3}, '{0,7,2,3}};
    b = tbl[cfg][w];
    if (b >= 4) b = b + 4 * ex;
    return b;
  endfunction

  function automatic logic [84:0] ref_pal();
    logic [84:0] v;
    for (int i = 0; i < 17; i++) v[i*5 +: 5] = m_pal[i];
    return v;
  endfunction

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_view(string tag);
    checks++;
    if (pal_out !== ref_pal()) begin
      errors++;
      $display("FAIL %s palette actual=%h expected=%h", tag, pal_out, ref_pal());
    end
    check_val({tag, " mode"}, int'(scr_mode), int'(m_mode));
    for (int w = 0; w < 4; w++) begin
      for (int wr = 0; wr < 2; wr++) begin
        mem_addr = {w[1:0], 14'($urandom)};
        mem_wr   = wr[0];
        #1;
        check_val({tag, " bank"}, int'(phys_bank), ref_bank(m_cfg, m_exp, w));
        check_val({tag, " rom"}, int'(rom_sel),
                  int'(wr == 0 && ((w == 0 && m_lo) || (w == 3 && m_hi))));
      end
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a[15:8] == 8'h7F) begin
      case (d[7:6])
        2'b00: m_sel = d[4] ? 16 : int'(d[3:0]);
        2'b01: m_pal[m_sel] = d[4:0];
        2'b10: begin m_mode = d[1:0]; m_lo = !d[2]; m_hi = !d[3]; end
        default: begin m_cfg = int'(d[2:0]); m_exp = int'(d[5:3]); end
      endcase
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_data = '0;
    mem_addr = '0; mem_wr = 1'b0;
    for (int i = 0; i < 17; i++) m_pal[i] = '0;
    m_sel = 0; m_mode = 2'd1; m_lo = 1'b1; m_hi = 1'b1; m_cfg = 0; m_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check_view("R9 reset");

    // R2 R3 pen 0 default, then border with an out-of-range colour
    io_write(16'h7F00, 8'h45);
    check_view("R3 pen0 colour");
    io_write(16'h7F12, 8'h10);
    io_write(16'h7F34, 8'h5F);
    check_view("R2 R3 border colour 31");
    io_write(16'h7F00, 8'h0F);
    io_write(16'h7FFF, 8'h5B);
    check_view("R2 pen15 colour 27");

    // R1 foreign port and low byte ignored
    io_write(16'h7E7F, 8'h8F);
    io_write(16'hFF00, 8'hFF);
    io_write(16'h0000, 8'h41);
    check_view("R1 foreign port");
    io_write(16'h7FA5, 8'h8E);
    check_view("R1 low byte ignored");

    // R4 bit 4 has no effect
    io_write(16'h7F00, 8'h80);
    check_view("R4 roms on mode0");
    io_write(16'h7F00, 8'h93);
    check_view("R4 bit4 ignored");

    // R10 nothing before the sampling edge
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h7F00; io_data = 8'h82;
    #5;
    check_val("R10 before edge", int'(scr_mode), int'(m_mode));
    @(negedge clk);
    io_wr = 1'b0;
    model_write(16'h7F00, 8'h82);
    check_view("R10 after edge");

    // R5 R6 every layout, expansion 0
    for (int c = 0; c < 8; c++) begin
      io_write(16'h7F00, 8'hC0 | 8'(c));
      check_view("R6 layout");
    end
    // R7 expansion banks
    io_write(16'h7F00, 8'hEA);
    check_view("R7 exp5 layout2");
    io_write(16'h7F00, 8'hFB);
    check_view("R7 exp7 layout3");
    io_write(16'h7F00, 8'hCC);
    check_view("R5 R7 exp1 layout4");

    // R8 ROM read/write split with both ROMs on then off
    io_write(16'h7F00, 8'h81);
    check_view("R8 roms on");
    io_write(16'h7F00, 8'h8D);
    check_view("R8 roms off");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      if ($urandom % 4 != 0) a[15:8] = 8'h7F;
      d = 8'($urandom);
      io_write(a, d);
      check_view("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule